// File: doc/BRIEF.md
# Selectable-Width Serial CRC Unit for Framed Links

This block produces and checks frame check sequences one bit at a time for a synchronous framed link. Each frame uses either the 16-bit CRC x^16+x^12+x^5+1 or the 32-bit Ethernet CRC. A configuration input picks the width: when the 32-bit select is high it replaces the 16-bit code in both the transmit and receive directions. A second configuration input makes the register start from all ones or from all zeros. Both inputs are sampled when the first bit of a frame is taken. A frame that is already running keeps the width and preset it started with. Only one width is ever active in a frame.

On the transmit side, data bits pass from an input stream to an output stream without change. After the bit marked last, the block appends 16 or 32 check bits to the output stream, most significant bit first. These check bits are inverted when the preset is all ones. Both streams use valid/ready handshakes. A bit moves when valid and ready are both high at a rising edge. While `tx_out_ready` is low, the output holds its bit. During data the input ready simply follows the output ready. During the trailer the input ready is held low.

On the receive side, every bit presented with `rx_in_valid` is taken, so the receive path has no back-pressure. The incoming bits run through the register, including the received check bits. When the last bit arrives, the final remainder is compared with the expected residue. The result is reported two ways:
- as a held status bit;
- as a one-cycle entry push, carrying the match flag and the width used, for a frame-status queue kept outside the block.

Top module: `crc_sel_frame_unit`

## Requirements
- R1: After reset, with no input valid: `tx_out_valid`, `rx_status_ok`, `rx_fifo_push` and `rx_fifo_ok` are all 0.
- R2: With `cfg_crc32`=0 a frame uses x^16+x^12+x^5+1 (0x1021), shifting the most significant bit first. With the all-ones preset the trailer of the nine bytes "123456789" (each byte sent bit 7 first) is 0xD64E.
- R3: With `cfg_crc32`=1 a frame uses the 32-bit Ethernet polynomial (0x04C11DB7), shifting the most significant bit first. With the all-ones preset the trailer of "123456789" is 0xFC891918.
- R4: `cfg_preset_ones`=0 starts the register at zero and sends the trailer uninverted. For "123456789" the trailer is then 0x31C3 (16-bit) or 0x89A1897F (32-bit).
- R5: During data, `tx_out_valid`=`tx_in_valid`, `tx_out_bit`=`tx_in_bit`, `tx_out_crc`=0 and `tx_in_ready`=`tx_out_ready`.
- R6: After the last data bit is accepted, the block emits the trailer, most significant bit first. Each trailer bit is the register bit inverted when the preset is ones. During the trailer `tx_out_valid`=1, `tx_out_crc`=1 and `tx_in_ready`=0.
- R7: While a trailer bit is offered and `tx_out_ready` is 0, the same bit stays on `tx_out_bit` in the next cycle.
- R8: The frame result is pushed two cycles after the rising edge that takes a receive bit with `rx_in_last`=1. At that point `rx_fifo_push` is high for exactly one cycle and `rx_status_ok` takes the result. `rx_status_ok` then holds until the next frame's result.
- R9: A receive frame is good when the final remainder equals:
  - 0x1D0F for 16-bit with the ones preset;
  - 0xC704DD7B for 32-bit with the ones preset;
  - zero with the zeros preset.
  A single flipped bit makes the result 0.
- R10: Width and preset are sampled at a frame's first accepted bit. Changing them in the middle of a frame has no effect on that frame.
- R11: A frame uses exactly one width. The transmit trailer is exactly 16 or 32 bits long, and `rx_fifo_wide` reports the width the frame used (1 = 32-bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_crc32 | input | 1 | 1 selects the 32-bit CRC, overriding the 16-bit code |
| cfg_preset_ones | input | 1 | 1 presets the register to all ones and inverts the trailer |
| tx_in_valid | input | 1 | Transmit data bit valid |
| tx_in_ready | output | 1 | Transmit data bit accepted when high with valid |
| tx_in_bit | input | 1 | Transmit data bit |
| tx_in_last | input | 1 | Marks the final data bit of a frame |
| tx_out_valid | output | 1 | Output bit valid |
| tx_out_ready | input | 1 | Downstream accepts the output bit |
| tx_out_bit | output | 1 | Output bit (data or trailer) |
| tx_out_crc | output | 1 | High while the output bit belongs to the trailer |
| rx_in_valid | input | 1 | Receive bit valid (always taken) |
| rx_in_bit | input | 1 | Receive bit, check bits included |
| rx_in_last | input | 1 | Marks the final received bit of a frame |
| rx_status_ok | output | 1 | Result of the most recent receive frame |
| rx_fifo_push | output | 1 | One-cycle push of a frame-status entry |
| rx_fifo_ok | output | 1 | Match flag of the pushed entry |
| rx_fifo_wide | output | 1 | Width of the pushed entry's frame (1 = 32-bit) |

## Verification
- **Transmit path.** Outputs are combinational from the current state and inputs. The bench drives each cycle after the falling edge and compares a moment later, before the rising edge that completes the handshake. It keeps a model queue of the expected data and trailer bits and pops it on every observed handshake.
- **Receive path.** The receive result arrives two rising edges after the last bit. The bench carries a two-stage expected-push pipeline and checks `rx_fifo_push` against it on every cycle. It checks the flag, the width and the status on the cycle the push is due, and checks that the status still holds one cycle later.

// File: rtl/crc_sel_pkg.sv
package crc_sel_pkg;

  localparam int WMAX  = 32;
  localparam int WNAR  = 16;
  localparam int CNT_W = $clog2(WMAX);

  localparam logic [WMAX-1:0] POLY_WIDE = 32'h04C1_1DB7;
  localparam logic [WMAX-1:0] POLY_NAR  = 32'h0000_1021;
  localparam logic [WMAX-1:0] RES_WIDE  = 32'hC704_DD7B;
  localparam logic [WMAX-1:0] RES_NAR   = 32'h0000_1D0F;
  localparam logic [WMAX-1:0] MASK_NAR  = (WMAX)'((64'd1 << WNAR) - 64'd1);

  // One serial step, most significant bit first; the narrow code keeps its upper half at zero.
  function automatic logic [WMAX-1:0] crc_step(input logic [WMAX-1:0] s,
                                               input logic b, input logic wide);
    logic fb;
    logic [WMAX-1:0] n;
    fb = (wide ? s[WMAX-1] : s[WNAR-1]) ^ b;
    n  = {s[WMAX-2:0], 1'b0};
    if (fb) n = n ^ (wide ? POLY_WIDE : POLY_NAR);
    if (!wide) n = n & MASK_NAR;
    return n;
  endfunction

  function automatic logic [WMAX-1:0] preset_val(input logic ones, input logic wide);
    if (!ones) return '0;
    return wide ? '1 : MASK_NAR;
  endfunction

  function automatic logic [WMAX-1:0] residue(input logic ones, input logic wide);
    if (!ones) return '0;
    return wide ? RES_WIDE : RES_NAR;
  endfunction

endpackage

// File: rtl/crc_sel_engine.sv
module crc_sel_engine
  import crc_sel_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_en,
  input  logic            first,
  input  logic            bit_in,
  input  logic            wide,
  input  logic            ones,
  input  logic            shift_en,
  output logic [WMAX-1:0] state_q
);

  logic [WMAX-1:0] base;

  assign base = first ? preset_val(ones, wide) : state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= '0;
    else if (step_en)  state_q <= crc_step(base, bit_in, wide);
    else if (shift_en) state_q <= {state_q[WMAX-2:0], 1'b0};
  end

  AST_STEP_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_en && shift_en)); // R6
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !wide) |=> (state_q[WMAX-1:WNAR] == '0)); // R2

endmodule

// File: rtl/crc_sel_tx.sv
module crc_sel_tx
  import crc_sel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wide,
  input  logic cfg_ones,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic in_last,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic out_crc
);

  typedef enum logic [1:0] {TX_IDLE, TX_DATA, TX_TRAIL} tx_st_e;

  tx_st_e           st_q;
  logic             wide_q, ones_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WMAX-1:0]  crc_q;
  logic             idle, trail, acc, trail_go, eff_wide, eff_ones, msb;

  assign idle     = (st_q == TX_IDLE);
  assign trail    = (st_q == TX_TRAIL);
  assign eff_wide = idle ? cfg_wide : wide_q;
  assign eff_ones = idle ? cfg_ones : ones_q;
  assign in_ready = !trail && out_ready;
  assign acc      = in_valid && in_ready;
  assign trail_go = trail && out_ready;
  assign msb      = wide_q ? crc_q[WMAX-1] : crc_q[WNAR-1];

  assign out_valid = trail ? 1'b1 : in_valid;
  assign out_bit   = trail ? (msb ^ ones_q) : in_bit;
  assign out_crc   = trail;

  crc_sel_engine u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (acc),
    .first   (idle),
    .bit_in  (in_bit),
    .wide    (eff_wide),
    .ones    (eff_ones),
    .shift_en(trail_go),
    .state_q (crc_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      wide_q <= 1'b0;
      ones_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (acc && idle) begin
        wide_q <= cfg_wide;
        ones_q <= cfg_ones;
      end
      if (acc) begin
        if (in_last) begin
          st_q  <= TX_TRAIL;
          cnt_q <= eff_wide ? CNT_W'(WMAX - 1) : CNT_W'(WNAR - 1);
        end else begin
          st_q  <= TX_DATA;
        end
      end else if (trail_go) begin
        if (cnt_q == '0) st_q  <= TX_IDLE;
        else             cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // Checker: number of trailer bits handed off in the current trailer.
  logic [CNT_W:0] chk_sent;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              chk_sent <= '0;
    else if (acc && in_last) chk_sent <= '0;
    else if (trail_go)       chk_sent <= chk_sent + 1'b1;
  end

  AST_TRAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (trail && !out_ready) |=> (out_valid && out_crc && $stable(out_bit))); // R7
  AST_TX_WIDTH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle) |=> ($stable(wide_q) && $stable(ones_q))); // R10
  AST_TRAIL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_go && cnt_q == '0) |->
      (chk_sent == (wide_q ? (CNT_W+1)'(WMAX - 1) : (CNT_W+1)'(WNAR - 1)))); // R11

endmodule

// File: rtl/crc_sel_rx.sv
module crc_sel_rx
  import crc_sel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wide,
  input  logic cfg_ones,
  input  logic in_valid,
  input  logic in_bit,
  input  logic in_last,
  output logic status_ok,
  output logic fifo_push,
  output logic fifo_ok,
  output logic fifo_wide
);

  logic            busy_q, wide_q, ones_q;
  logic            pend_q, pend_wide_q, pend_ones_q;
  logic            push_q, ok_q, fwide_q;
  logic            eff_wide, eff_ones, first, fin;
  logic [WMAX-1:0] crc_q;

  assign first    = !busy_q;
  assign eff_wide = first ? cfg_wide : wide_q;
  assign eff_ones = first ? cfg_ones : ones_q;
  assign fin      = in_valid && in_last;

  crc_sel_engine u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (in_valid),
    .first   (first),
    .bit_in  (in_bit),
    .wide    (eff_wide),
    .ones    (eff_ones),
    .shift_en(1'b0),
    .state_q (crc_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      wide_q      <= 1'b0;
      ones_q      <= 1'b0;
      pend_q      <= 1'b0;
      pend_wide_q <= 1'b0;
      pend_ones_q <= 1'b0;
      push_q      <= 1'b0;
      ok_q        <= 1'b0;
      fwide_q     <= 1'b0;
    end else begin
      if (in_valid) begin
        busy_q <= !in_last;
        if (first) begin
          wide_q <= cfg_wide;
          ones_q <= cfg_ones;
        end
      end
      pend_q <= fin;
      if (fin) begin
        pend_wide_q <= eff_wide;
        pend_ones_q <= eff_ones;
      end
      push_q <= pend_q;
      if (pend_q) begin
        ok_q    <= (crc_q == residue(pend_ones_q, pend_wide_q));
        fwide_q <= pend_wide_q;
      end
    end
  end

  assign status_ok = ok_q;
  assign fifo_ok   = ok_q;
  assign fifo_push = push_q;
  assign fifo_wide = fwide_q;

  AST_PUSH_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> ##1 fifo_push); // R8
  AST_NO_STRAY_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> ##1 !fifo_push); // R8
  AST_RX_WIDTH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(wide_q) && $stable(ones_q))); // R10

endmodule

// File: rtl/crc_sel_frame_unit.sv
module crc_sel_frame_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_crc32,
  input  logic cfg_preset_ones,
  input  logic tx_in_valid,
  output logic tx_in_ready,
  input  logic tx_in_bit,
  input  logic tx_in_last,
  output logic tx_out_valid,
  input  logic tx_out_ready,
  output logic tx_out_bit,
  output logic tx_out_crc,
  input  logic rx_in_valid,
  input  logic rx_in_bit,
  input  logic rx_in_last,
  output logic rx_status_ok,
  output logic rx_fifo_push,
  output logic rx_fifo_ok,
  output logic rx_fifo_wide
);

  crc_sel_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wide (cfg_crc32),
    .cfg_ones (cfg_preset_ones),
    .in_valid (tx_in_valid),
    .in_ready (tx_in_ready),
    .in_bit   (tx_in_bit),
    .in_last  (tx_in_last),
    .out_valid(tx_out_valid),
    .out_ready(tx_out_ready),
    .out_bit  (tx_out_bit),
    .out_crc  (tx_out_crc)
  );

  crc_sel_rx u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wide (cfg_crc32),
    .cfg_ones (cfg_preset_ones),
    .in_valid (rx_in_valid),
    .in_bit   (rx_in_bit),
    .in_last  (rx_in_last),
    .status_ok(rx_status_ok),
    .fifo_push(rx_fifo_push),
    .fifo_ok  (rx_fifo_ok),
    .fifo_wide(rx_fifo_wide)
  );

  AST_RESULT_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fifo_push |-> (rx_status_ok == rx_fifo_ok)); // R8

endmodule

// File: tb/tb_crc_sel_frame_unit.sv
`timescale 1ns/1ps
module tb_crc_sel_frame_unit;

  typedef bit bq_t[$];

  logic clk, rst_n, cfg_crc32, cfg_preset_ones;
  logic tx_in_valid, tx_in_ready, tx_in_bit, tx_in_last;
  logic tx_out_valid, tx_out_ready, tx_out_bit, tx_out_crc;
  logic rx_in_valid, rx_in_bit, rx_in_last;
  logic rx_status_ok, rx_fifo_push, rx_fifo_ok, rx_fifo_wide;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  crc_sel_frame_unit dut (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input bq_t d, input bit wide, input bit ones);
    int w;
    longint unsigned poly, mask, r, top;
    w    = wide ? 32 : 16;
    poly = wide ? 64'h04C11DB7 : 64'h1021;
    mask = (64'd1 << w) - 1;
    r    = ones ? mask : 0;
    foreach (d[i]) begin
      top = (r >> (w - 1)) & 1;
      r   = (r << 1) & mask;
      if ((top ^ longint'(d[i])) != 0) r = r ^ poly;
    end
    return r[31:0];
  endfunction

  function automatic bq_t str_bits(input string s);
    bq_t q;
    for (int i = 0; i < s.len(); i++)
      for (int b = 7; b >= 0; b--) q.push_back(s[i][b]);
    return q;
  endfunction

  function automatic bq_t rand_bits(input int n);
    bq_t q;
    for (int i = 0; i < n; i++) q.push_back(bit'($urandom_range(1)));
    return q;
  endfunction

  function automatic bq_t with_trailer(input bq_t d, input bit wide, input bit ones);
    bq_t q;
    logic [31:0] raw;
    q   = d;
    raw = ref_crc(d, wide, ones);
    for (int i = (wide ? 31 : 15); i >= 0; i--) q.push_back(raw[i] ^ ones);
    return q;
  endfunction

  task automatic tx_frame(input bq_t d, input bit wide, input bit ones, input bit flip,
                          input string req, output logic [31:0] tv, output int tn);
    bq_t exp;
    bit  expf[$];
    int  idx;
    bit  held, held_bit;
    exp = with_trailer(d, wide, ones);
    foreach (exp[i]) expf.push_back(i >= d.size());
    idx = 0; held = 0; held_bit = 0; tv = 0; tn = 0;
    cfg_crc32 = wide; cfg_preset_ones = ones;
    while (exp.size() > 0) begin
      @(negedge clk);
      if (flip && idx == d.size() / 2) begin
        cfg_crc32 = !wide; cfg_preset_ones = !ones;  // R10: must not affect this frame
      end
      if (idx < d.size()) begin
        tx_in_valid = ($urandom_range(3) != 0);
        tx_in_bit   = d[idx];
        tx_in_last  = (idx == d.size() - 1);
      end else begin
        tx_in_valid = 0; tx_in_bit = 0; tx_in_last = 0;
      end
      tx_out_ready = ($urandom_range(2) != 0);
      #1;
      if (idx >= d.size())
        chk("R6", "trailer valid/crc/in_ready", {tx_out_valid, tx_out_crc, tx_in_ready}, 3'b110);
      else
        chk("R5", "pass valid/crc/ready", {tx_out_valid, tx_out_crc, tx_in_ready},
            {tx_in_valid, 1'b0, tx_out_ready});
      if (held) chk("R7", "held trailer bit", tx_out_bit, held_bit);
      held = (idx >= d.size()) && !tx_out_ready;
      held_bit = tx_out_bit;
      if (tx_out_valid && tx_out_ready) begin
        chk(req, "output bit", tx_out_bit, exp[0]);
        chk("R6", "trailer flag", tx_out_crc, expf[0]);
        if (expf[0]) begin
          tv = {tv[30:0], tx_out_bit};
          tn++;
        end
        void'(exp.pop_front());
        void'(expf.pop_front());
      end
      if (tx_in_valid && tx_in_ready) idx++;
    end
    @(negedge clk);
    tx_in_valid = 0; tx_in_last = 0; tx_out_ready = 0;
    chk("R11", "trailer length", tn, wide ? 32 : 16);
  endtask

  task automatic rx_frame(input bq_t d, input bit wide, input bit ones, input bit corrupt,
                          input bit flip, input string req);
    bq_t f;
    int  idx;
    bit  p1, p2, exp_ok;
    f = with_trailer(d, wide, ones);
    if (corrupt) f[2] = ~f[2];
    exp_ok = !corrupt;
    idx = 0; p1 = 0; p2 = 0;
    cfg_crc32 = wide; cfg_preset_ones = ones;
    while (idx < f.size() || p1 || p2) begin
      @(negedge clk);
      if (flip && idx == f.size() / 2) begin
        cfg_crc32 = !wide; cfg_preset_ones = !ones;  // R10: must not affect this frame
      end
      if (idx < f.size()) begin
        rx_in_valid = ($urandom_range(3) != 0);
        rx_in_bit   = f[idx];
        rx_in_last  = (idx == f.size() - 1);
      end else begin
        rx_in_valid = 0; rx_in_bit = 0; rx_in_last = 0;
      end
      #1;
      chk("R8", "push timing", rx_fifo_push, p2);
      if (p2) begin
        chk(req, "fifo ok", rx_fifo_ok, exp_ok);
        chk("R8", "status ok", rx_status_ok, exp_ok);
        chk("R11", "fifo width", rx_fifo_wide, wide);
      end
      p2 = p1;
      p1 = rx_in_valid && rx_in_last;
      if (rx_in_valid) idx++;
    end
    @(negedge clk);
    #1;
    chk("R8", "push single cycle", rx_fifo_push, 1'b0);
    chk("R8", "status holds", rx_status_ok, exp_ok);
  endtask

  initial begin
    logic [31:0] tv;
    int tn;
    bq_t nine;
    rst_n = 0; cfg_crc32 = 0; cfg_preset_ones = 1;
    tx_in_valid = 0; tx_in_bit = 0; tx_in_last = 0; tx_out_ready = 0;
    rx_in_valid = 0; rx_in_bit = 0; rx_in_last = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1", "reset outputs", {tx_out_valid, rx_status_ok, rx_fifo_push, rx_fifo_ok}, 4'b0000);

    nine = str_bits("123456789");
    tx_frame(nine, 0, 1, 0, "R2", tv, tn);
    chk("R2", "16-bit ones check value", tv, 32'h0000D64E);
    tx_frame(nine, 1, 1, 0, "R3", tv, tn);
    chk("R3", "32-bit ones check value", tv, 32'hFC891918);
    tx_frame(nine, 0, 0, 0, "R4", tv, tn);
    chk("R4", "16-bit zeros check value", tv, 32'h000031C3);
    tx_frame(nine, 1, 0, 0, "R4", tv, tn);
    chk("R4", "32-bit zeros check value", tv, 32'h89A1897F);
    tx_frame(rand_bits(1), 1, 1, 0, "R6", tv, tn);
    tx_frame(rand_bits(40), 0, 1, 1, "R10", tv, tn);
    tx_frame(rand_bits(57), 1, 0, 1, "R10", tv, tn);
    for (int k = 0; k < 8; k++)
      tx_frame(rand_bits(8 + k * 5), k[0], k[1], 0, "R5", tv, tn);

    rx_frame(nine, 0, 1, 0, 0, "R9");
    rx_frame(nine, 1, 1, 0, 0, "R9");
    rx_frame(rand_bits(33), 0, 0, 0, 0, "R9");
    rx_frame(rand_bits(45), 1, 0, 0, 0, "R9");
    rx_frame(rand_bits(30), 1, 1, 1, 0, "R9");
    rx_frame(rand_bits(30), 0, 1, 1, 0, "R9");
    rx_frame(rand_bits(50), 1, 1, 0, 1, "R10");
    rx_frame(rand_bits(50), 0, 0, 0, 1, "R10");
    for (int k = 0; k < 6; k++)
      rx_frame(rand_bits(12 + k * 7), k[0], k[1], k[2], 0, "R9");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule